// File: doc/BRIEF.md
# Fully Associative Address Translation Cache

This block caches recent page translations for a 32-bit virtual address space with 4 KB pages. A lookup presents a virtual address and an access kind. Every cached tag is compared at the same time. The registered result comes back on the next clock edge as a hit, a miss or a protection fault. On a hit the physical address is the cached frame number with the page offset appended unchanged. The updated page table entry is also returned, so the caller can see its usage and dirty marks.

An external table walker answers misses through a valid/ready refill port. A refill goes into the entry that already holds the same page, or else into a free entry, or else into the least recently used entry. Software keeps the cache consistent in two ways. It can drop one page after changing that page's permissions, and it can empty the whole cache on a context switch.

Top module: `tlb_xlate`

## Requirements
- R1: The virtual page number is address bits 31:12 and the offset is bits 11:0. On a hit, res_paddr equals the cached 20-bit frame number followed by the offset. The result appears on the first clock edge after the lookup is presented.
- R2: Each accepted lookup raises exactly one of res_hit, res_miss or res_fault, for one cycle. In cycles that follow no accepted lookup, all three are low and res_paddr and res_pte are zero.
- R3: An entry whose live bit (entry bit 0) is clear never translates, and a lookup of its page reports a miss.
- R4: Entry bits 4:3 hold the permission code: 00 none, 01 read only, 10 read/write, 11 read/execute. res_lk_kind uses 00 read, 01 write, 10 execute and 11 reserved. A reserved kind always faults. A disallowed access raises res_fault with zero address and entry outputs, and leaves the entry unchanged.
- R5: A hit sets the usage bit (entry bit 1), and a write hit also sets the dirty bit (entry bit 2). res_pte shows the entry after this update, with the frame number in bits 24:5.
- R6: Asserting flush for one cycle clears the live bit of every entry.
- R7: An invalidate clears only the entry that holds inv_vpn. Other pages keep translating.
- R8: A refill is taken on a clock edge where fill_valid and fill_ready are both high. fill_ready is low whenever a lookup, an invalidate or a flush is presented, and a refill offered in such a cycle is not stored.
- R9: A refill for a page that is already live overwrites that entry in place, so later lookups see the new entry.
- R10: A refill goes into a free entry before any live entry is evicted, so 16 distinct pages can be resident together.
- R11: When every entry is live, a refill evicts the least recently used entry. Refills and successful hits count as uses; faulting accesses do not.
- R12: After reset, no entry is live, every lookup misses, all outputs are zero and fill_ready is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_kind | input | 2 | Access kind: 00 read, 01 write, 10 execute, 11 reserved |
| res_hit | output | 1 | Translation succeeded |
| res_miss | output | 1 | No live entry for the page |
| res_fault | output | 1 | Entry found but access not permitted |
| res_paddr | output | 32 | Physical address on a hit, else zero |
| res_pte | output | 25 | Updated entry on a hit, else zero |
| fill_valid | input | 1 | Refill offered by the walker |
| fill_ready | output | 1 | Refill can be taken this cycle |
| fill_vpn | input | 20 | Page number for the refill |
| fill_pte | input | 25 | Entry to store: frame, permission, dirty, usage, live |
| inv_valid | input | 1 | Drop the entry for inv_vpn |
| inv_vpn | input | 20 | Page number to drop |
| flush | input | 1 | Clear all entries |

## Verification
A corrupted tag or frame register shows up on the next lookup of that page, either as a wrong physical address or as a miss where a hit was due. Damaged recency state does not show at once. It appears only when a full cache evicts a page that the reference model still holds, so the bench fills the cache completely and then probes both the expected victim and the survivors. Lost usage or dirty updates, or stray permission decoding, show up in res_pte and in the hit/fault outcome of the next access to the same page.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  parameter int VA_W  = 32;
  parameter int OFF_W = 12;
  parameter int VPN_W = VA_W - OFF_W;
  parameter int PFN_W = 20;
  parameter int PA_W  = PFN_W + OFF_W;

  typedef enum logic [1:0] {
    ACC_READ  = 2'b00,
    ACC_WRITE = 2'b01,
    ACC_EXEC  = 2'b10,
    ACC_RSVD  = 2'b11
  } acc_e;

  typedef enum logic [1:0] {
    PERM_NONE = 2'b00,
    PERM_RO   = 2'b01,
    PERM_RW   = 2'b10,
    PERM_RX   = 2'b11
  } perm_e;

  typedef struct packed {
    logic [PFN_W-1:0] pfn;
    perm_e            perm;
    logic             dirty;
    logic             used;
    logic             live;
  } pte_t;

  localparam int PTE_W = $bits(pte_t);
endpackage

// File: rtl/tlb_cam.sv
module tlb_cam #(
  parameter int N     = 16,
  parameter int W     = 20,
  parameter int IDX_W = 4
) (
  input  logic [N-1:0] live,
  input  logic [W-1:0] tags [N],
  input  logic [W-1:0] key,
  output logic         any,
  output logic [IDX_W-1:0] idx
);
  logic [N-1:0] match;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign match[g] = live[g] && (tags[g] == key);
  end

  assign any = |match;

  always_comb begin
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (match[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/tlb_perm.sv
module tlb_perm
  import tlb_pkg::*;
(
  input  perm_e perm,
  input  acc_e  kind,
  output logic  allow
);
  always_comb begin
    allow = 1'b0;
    unique case (kind)
      ACC_READ:  allow = (perm != PERM_NONE);
      ACC_WRITE: allow = (perm == PERM_RW);
      ACC_EXEC:  allow = (perm == PERM_RX);
      ACC_RSVD:  allow = 1'b0;
      default:   allow = 1'b0;
    endcase
  end
endmodule

// File: rtl/tlb_lru.sv
module tlb_lru #(
  parameter int N     = 16,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             touch,
  input  logic [IDX_W-1:0] touch_idx,
  input  logic [N-1:0]     live,
  output logic [IDX_W-1:0] pick_idx
);
  localparam int AGE_W = IDX_W;
  localparam logic [AGE_W-1:0] AGE_MAX = AGE_W'(N - 1);

  logic [AGE_W-1:0] age_q [N];
  logic [AGE_W-1:0] age_d [N];
  logic [IDX_W-1:0] oldest_idx;
  logic [IDX_W-1:0] free_idx;
  logic             have_free;

  // recency rank: 0 = most recent, N-1 = least recent
  always_comb begin
    age_d = age_q;
    if (touch) begin
      for (int j = 0; j < N; j++) begin
        if (IDX_W'(j) == touch_idx) age_d[j] = '0;
        else if (age_q[j] < age_q[touch_idx]) age_d[j] = age_q[j] + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int j = 0; j < N; j++) age_q[j] <= AGE_W'(j);
    end else if (touch) begin
      age_q <= age_d;
    end
  end

  always_comb begin
    oldest_idx = '0;
    for (int j = 0; j < N; j++) begin
      if (age_q[j] == AGE_MAX) oldest_idx = IDX_W'(j);
    end
  end

  always_comb begin
    have_free = 1'b0;
    free_idx  = '0;
    for (int j = N - 1; j >= 0; j--) begin
      if (!live[j]) begin
        have_free = 1'b1;
        free_idx  = IDX_W'(j);
      end
    end
  end

  assign pick_idx = have_free ? free_idx : oldest_idx;
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [VA_W-1:0]   lk_vaddr,
  input  logic [1:0]        lk_kind,
  output logic              res_hit,
  output logic              res_miss,
  output logic              res_fault,
  output logic [PA_W-1:0]   res_paddr,
  output logic [PTE_W-1:0]  res_pte,
  input  logic              fill_valid,
  output logic              fill_ready,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic [PTE_W-1:0]  fill_pte,
  input  logic              inv_valid,
  input  logic [VPN_W-1:0]  inv_vpn,
  input  logic              flush
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [VPN_W-1:0] tag_q [ENTRIES];
  logic [VPN_W-1:0] tag_d [ENTRIES];
  pte_t             pte_q [ENTRIES];
  pte_t             pte_d [ENTRIES];
  logic [ENTRIES-1:0] live_vec;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_live
    assign live_vec[g] = pte_q[g].live;
  end

  // operation select: flush, then invalidate, then lookup, then refill
  logic lookup_go, inv_go, fill_go;
  assign lookup_go  = lk_valid && !flush && !inv_valid;
  assign inv_go     = inv_valid && !flush;
  assign fill_ready = !lk_valid && !inv_valid && !flush;
  assign fill_go    = fill_valid && fill_ready;

  logic [VPN_W-1:0] key;
  always_comb begin
    if (inv_valid)     key = inv_vpn;
    else if (lk_valid) key = lk_vaddr[VA_W-1:OFF_W];
    else               key = fill_vpn;
  end

  logic             cam_any;
  logic [IDX_W-1:0] cam_idx;
  tlb_cam #(.N(ENTRIES), .W(VPN_W), .IDX_W(IDX_W)) u_cam (
    .live (live_vec),
    .tags (tag_q),
    .key  (key),
    .any  (cam_any),
    .idx  (cam_idx)
  );

  acc_e kind;
  pte_t hit_pte;
  logic allow;
  assign kind    = acc_e'(lk_kind);
  assign hit_pte = pte_q[cam_idx];

  tlb_perm u_perm (
    .perm  (hit_pte.perm),
    .kind  (kind),
    .allow (allow)
  );

  logic acc_ok, acc_bad, acc_miss;
  assign acc_ok   = lookup_go && cam_any && allow;
  assign acc_bad  = lookup_go && cam_any && !allow;
  assign acc_miss = lookup_go && !cam_any;

  logic [IDX_W-1:0] pick_idx, wr_idx, touch_idx;
  logic             touch;
  assign wr_idx    = cam_any ? cam_idx : pick_idx;
  assign touch     = acc_ok || fill_go;
  assign touch_idx = fill_go ? wr_idx : cam_idx;

  tlb_lru #(.N(ENTRIES), .IDX_W(IDX_W)) u_lru (
    .clk       (clk),
    .rst_n     (rst_n),
    .touch     (touch),
    .touch_idx (touch_idx),
    .live      (live_vec),
    .pick_idx  (pick_idx)
  );

  pte_t upd_pte;
  always_comb begin
    upd_pte       = hit_pte;
    upd_pte.used  = 1'b1;
    upd_pte.dirty = hit_pte.dirty || (kind == ACC_WRITE);
  end

  // entry array next state
  logic ent_en;
  always_comb begin
    tag_d  = tag_q;
    pte_d  = pte_q;
    ent_en = 1'b0;
    if (flush) begin
      ent_en = 1'b1;
      for (int i = 0; i < ENTRIES; i++) pte_d[i].live = 1'b0;
    end else if (inv_go) begin
      ent_en = cam_any;
      pte_d[cam_idx].live = 1'b0;
    end else if (acc_ok) begin
      ent_en = 1'b1;
      pte_d[cam_idx] = upd_pte;
    end else if (fill_go) begin
      ent_en = 1'b1;
      tag_d[wr_idx] = fill_vpn;
      pte_d[wr_idx] = pte_t'(fill_pte);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) begin
        tag_q[i] <= '0;
        pte_q[i] <= '0;
      end
    end else if (ent_en) begin
      tag_q <= tag_d;
      pte_q <= pte_d;
    end
  end

  // response next state
  logic             hit_d, miss_d, fault_d;
  logic [PA_W-1:0]  paddr_d;
  logic [PTE_W-1:0] rpte_d;
  always_comb begin
    hit_d   = acc_ok;
    miss_d  = acc_miss;
    fault_d = acc_bad;
    paddr_d = '0;
    rpte_d  = '0;
    if (acc_ok) begin
      paddr_d = {hit_pte.pfn, lk_vaddr[OFF_W-1:0]};
      rpte_d  = upd_pte;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_hit   <= 1'b0;
      res_miss  <= 1'b0;
      res_fault <= 1'b0;
      res_paddr <= '0;
      res_pte   <= '0;
    end else begin
      res_hit   <= hit_d;
      res_miss  <= miss_d;
      res_fault <= fault_d;
      res_paddr <= paddr_d;
      res_pte   <= rpte_d;
    end
  end
endmodule

// File: rtl/tlb_xlate_chk.sv
module tlb_xlate_chk
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               lk_valid,
  input logic [VA_W-1:0]    lk_vaddr,
  input logic [1:0]         lk_kind,
  input logic               inv_valid,
  input logic               flush,
  input logic               fill_ready,
  input logic               res_hit,
  input logic               res_miss,
  input logic               res_fault,
  input logic [PA_W-1:0]    res_paddr,
  input logic [PTE_W-1:0]   res_pte,
  input logic [ENTRIES-1:0] live_vec
);
  AST_SINGLE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({res_hit, res_miss, res_fault}) <= 1); // R2
  AST_LOOKUP_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && !flush && !inv_valid) |=> (res_hit || res_miss || res_fault)); // R2
  AST_NO_SPURIOUS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    !(lk_valid && !flush && !inv_valid) |=> !(res_hit || res_miss || res_fault)); // R2
  AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    res_hit |-> (res_paddr[OFF_W-1:0] == $past(lk_vaddr[OFF_W-1:0]))); // R1
  AST_HIT_MARKS_USED: assert property (@(posedge clk) disable iff (!rst_n)
    res_hit |-> (res_pte[1] && res_pte[0])); // R5
  AST_WRITE_MARKS_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
    (res_hit && ($past(lk_kind) == 2'b01)) |-> res_pte[2]); // R5
  AST_NO_XLATE_ON_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (res_fault || res_miss) |-> (res_paddr == '0 && res_pte == '0)); // R4
  AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (live_vec == '0)); // R6
  AST_FILL_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid || inv_valid || flush) |-> !fill_ready); // R8
endmodule

bind tlb_xlate tlb_xlate_chk #(.ENTRIES(ENTRIES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .lk_valid   (lk_valid),
  .lk_vaddr   (lk_vaddr),
  .lk_kind    (lk_kind),
  .inv_valid  (inv_valid),
  .flush      (flush),
  .fill_ready (fill_ready),
  .res_hit    (res_hit),
  .res_miss   (res_miss),
  .res_fault  (res_fault),
  .res_paddr  (res_paddr),
  .res_pte    (res_pte),
  .live_vec   (live_vec)
);

// File: tb/tlb_xlate_test.sv
module tlb_xlate_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        lk_valid;
  logic [31:0] lk_vaddr;
  logic [1:0]  lk_kind;
  logic        res_hit, res_miss, res_fault;
  logic [31:0] res_paddr;
  logic [24:0] res_pte;
  logic        fill_valid;
  logic        fill_ready;
  logic [19:0] fill_vpn;
  logic [24:0] fill_pte;
  logic        inv_valid;
  logic [19:0] inv_vpn;
  logic        flush;

  always #10 clk = ~clk;

  tlb_xlate uut (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
    .lk_kind(lk_kind), .res_hit(res_hit), .res_miss(res_miss),
    .res_fault(res_fault), .res_paddr(res_paddr), .res_pte(res_pte),
    .fill_valid(fill_valid), .fill_ready(fill_ready), .fill_vpn(fill_vpn),
    .fill_pte(fill_pte), .inv_valid(inv_valid), .inv_vpn(inv_vpn), .flush(flush)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  // reference model: 16 slots, order irrelevant, last-use stamps
  logic [19:0] m_tag [16];
  logic [24:0] m_pte [16];
  longint      m_stamp [16];
  longint      tick = 0;

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [24:0] mk_pte(input logic [19:0] pfn, input logic [1:0] perm,
                                         input logic d, input logic u, input logic v);
    return {pfn, perm, d, u, v};
  endfunction

  function automatic bit permits(input logic [1:0] perm, input logic [1:0] kind);
    case (kind)
      2'b00:   return perm != 2'b00;
      2'b01:   return perm == 2'b10;
      2'b10:   return perm == 2'b11;
      default: return 1'b0;
    endcase
  endfunction

  function automatic int m_find(input logic [19:0] vpn);
    for (int i = 0; i < 16; i++) if (m_pte[i][0] && m_tag[i] == vpn) return i;
    return -1;
  endfunction

  function automatic void m_fill(input logic [19:0] vpn, input logic [24:0] pte);
    int s;
    s = m_find(vpn);
    if (s < 0) for (int i = 15; i >= 0; i--) if (!m_pte[i][0]) s = i;
    if (s < 0) begin
      s = 0;
      for (int i = 1; i < 16; i++) if (m_stamp[i] < m_stamp[s]) s = i;
    end
    tick++;
    m_tag[s] = vpn; m_pte[s] = pte; m_stamp[s] = tick;
  endfunction

  task automatic idle_check(input string req);
    chk(req, "idle outcome", {res_hit, res_miss, res_fault}, 3'b000);
    chk(req, "idle paddr", res_paddr, 32'h0);
  endtask

  task automatic lookup(input string req, input logic [31:0] va, input logic [1:0] kind,
                        output bit was_miss);
    int s;
    logic [2:0] e_out;
    logic [31:0] e_pa;
    logic [24:0] e_pte;
    s = m_find(va[31:12]);
    e_pa = 0; e_pte = 0;
    if (s < 0) e_out = 3'b010;
    else if (!permits(m_pte[s][4:3], kind)) e_out = 3'b001;
    else begin
      e_out = 3'b100;
      m_pte[s][1] = 1'b1;
      if (kind == 2'b01) m_pte[s][2] = 1'b1;
      tick++; m_stamp[s] = tick;
      e_pa = {m_pte[s][24:5], va[11:0]};
      e_pte = m_pte[s];
    end
    was_miss = (s < 0);
    @(negedge clk);
    lk_valid = 1'b1; lk_vaddr = va; lk_kind = kind;
    @(negedge clk);
    lk_valid = 1'b0;
    chk(req, "outcome hit/miss/fault", {res_hit, res_miss, res_fault}, e_out);
    chk(req, "paddr", res_paddr, e_pa);
    chk(req, "pte", res_pte, e_pte);
  endtask

  task automatic refill(input string req, input logic [19:0] vpn, input logic [24:0] pte);
    @(negedge clk);
    fill_valid = 1'b1; fill_vpn = vpn; fill_pte = pte;
    #1 chk("R8", "fill_ready idle", fill_ready, 1'b1);
    @(negedge clk);
    fill_valid = 1'b0;
    idle_check(req);
    m_fill(vpn, pte);
  endtask

  task automatic drop(input logic [19:0] vpn);
    int s;
    s = m_find(vpn);
    if (s >= 0) m_pte[s][0] = 1'b0;
    @(negedge clk);
    inv_valid = 1'b1; inv_vpn = vpn;
    #1 chk("R8", "fill_ready during invalidate", fill_ready, 1'b0);
    @(negedge clk);
    inv_valid = 1'b0;
    idle_check("R7");
  endtask

  task automatic wipe();
    for (int i = 0; i < 16; i++) m_pte[i][0] = 1'b0;
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    idle_check("R6");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    bit miss;
    logic [19:0] v;
    void'($urandom(32'h5eed_0042));
    for (int i = 0; i < 16; i++) begin
      m_tag[i] = 0; m_pte[i] = 0; m_stamp[i] = 0;
    end
    rst_n = 1'b0; lk_valid = 0; lk_vaddr = 0; lk_kind = 0;
    fill_valid = 0; fill_vpn = 0; fill_pte = 0; inv_valid = 0; inv_vpn = 0; flush = 0;
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12", "reset outcome", {res_hit, res_miss, res_fault}, 3'b000);
    chk("R12", "reset pte", res_pte, 25'h0);
    chk("R12", "reset fill_ready", fill_ready, 1'b1);
    rst_n = 1'b1;
    lookup("R12", 32'h13325328, 2'b00, miss);
    chk("R12", "empty lookup misses", miss, 1'b1);

    // R1 / R5 basic translation and usage marks
    refill("R1", 20'h13325, mk_pte(20'h03004, 2'b10, 0, 0, 1));
    lookup("R1", 32'h13325328, 2'b00, miss);
    chk("R1", "paddr value", res_paddr, 32'h03004328);
    chk("R5", "used bit after read", res_pte[2:0], 3'b011);
    lookup("R5", 32'h13325FFC, 2'b01, miss);
    chk("R5", "dirty bit after write", res_pte[2:0], 3'b111);

    // R4 permission decoding
    refill("R4", 20'h00A01, mk_pte(20'h11111, 2'b01, 0, 0, 1));
    lookup("R4", 32'h00A01010, 2'b01, miss);
    chk("R4", "write to read-only faults", res_fault, 1'b1);
    lookup("R4", 32'h00A01020, 2'b10, miss);
    lookup("R4", 32'h00A01030, 2'b00, miss);
    chk("R4", "dirty not set by faulting write", res_pte[2], 1'b0);
    refill("R4", 20'h00A02, mk_pte(20'h22222, 2'b11, 0, 0, 1));
    lookup("R4", 32'h00A02000, 2'b10, miss);
    lookup("R4", 32'h00A02000, 2'b01, miss);
    lookup("R4", 32'h00A02000, 2'b11, miss);
    refill("R4", 20'h00A03, mk_pte(20'h33333, 2'b00, 0, 0, 1));
    lookup("R4", 32'h00A03000, 2'b00, miss);
    chk("R4", "no-access read faults", res_fault, 1'b1);

    // R3 dead entry
    refill("R3", 20'h00B00, mk_pte(20'h44444, 2'b10, 0, 0, 0));
    lookup("R3", 32'h00B00abc, 2'b00, miss);
    chk("R3", "dead entry misses", miss, 1'b1);

    // R9 in-place replacement
    refill("R9", 20'h13325, mk_pte(20'h0BEEF, 2'b10, 0, 0, 1));
    lookup("R9", 32'h13325004, 2'b00, miss);
    chk("R9", "replaced frame", res_paddr, 32'h0BEEF004);

    // R10 / R11 fill to capacity, then LRU eviction
    wipe();
    for (int i = 0; i < 16; i++)
      refill("R10", 20'h40000 + 20'(i), mk_pte(20'h60000 + 20'(i), (i == 1) ? 2'b01 : 2'b10, 0, 0, 1));
    for (int i = 0; i < 16; i++) begin
      lookup("R10", {20'h40000 + 20'(i), 12'h010}, 2'b00, miss);
      chk("R10", "all 16 resident", miss, 1'b0);
    end
    lookup("R11", {20'h40000, 12'h0}, 2'b00, miss);
    lookup("R11", {20'h40001, 12'h0}, 2'b01, miss);
    chk("R11", "fault on entry 1", res_fault, 1'b1);
    refill("R11", 20'h4ABCD, mk_pte(20'h7FFFF, 2'b10, 0, 0, 1));
    lookup("R11", {20'h40001, 12'h0}, 2'b00, miss);
    chk("R11", "LRU page evicted", miss, 1'b1);
    lookup("R11", {20'h40000, 12'h0}, 2'b00, miss);
    chk("R11", "refreshed page kept", miss, 1'b0);
    lookup("R11", {20'h4ABCD, 12'h0}, 2'b00, miss);
    chk("R11", "new page present", miss, 1'b0);

    // R7 single invalidate
    drop(20'h40002);
    lookup("R7", {20'h40002, 12'h0}, 2'b00, miss);
    chk("R7", "dropped page misses", miss, 1'b1);
    lookup("R7", {20'h40003, 12'h0}, 2'b00, miss);
    chk("R7", "neighbour still hits", miss, 1'b0);

    // R8 refill offered with a lookup is not taken
    begin
      int s;
      s = m_find(20'h40004);
      m_pte[s][1] = 1'b1; tick++; m_stamp[s] = tick;
      @(negedge clk);
      lk_valid = 1; lk_vaddr = {20'h40004, 12'h0}; lk_kind = 2'b00;
      fill_valid = 1; fill_vpn = 20'h5DEAD; fill_pte = mk_pte(20'h1, 2'b10, 0, 0, 1);
      #1 chk("R8", "fill_ready with lookup", fill_ready, 1'b0);
      @(negedge clk);
      lk_valid = 0; fill_valid = 0;
      chk("R8", "concurrent lookup hit", res_hit, 1'b1);
    end
    lookup("R8", {20'h5DEAD, 12'h0}, 2'b00, miss);
    chk("R8", "blocked refill not stored", miss, 1'b1);

    // R6 flush
    wipe();
    for (int i = 0; i < 4; i++) begin
      lookup("R6", {20'h40000 + 20'(4 * i), 12'h0}, 2'b00, miss);
      chk("R6", "flushed page misses", miss, 1'b1);
    end

    // random mix against the model
    for (int n = 0; n < 2500; n++) begin
      int op;
      op = int'($urandom % 100);
      v = 20'h50000 + 20'($urandom % 24);
      if (op < 90) begin
        lookup("R11", {v, 12'($urandom)}, ($urandom % 8 == 0) ? 2'b11 : 2'($urandom % 3), miss);
        if (miss)
          refill("R10", v, mk_pte(20'($urandom), 2'($urandom), 1'($urandom), 1'($urandom),
                                  ($urandom % 10) != 0));
      end else if (op < 98) begin
        drop(v);
      end else begin
        wipe();
      end
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule